// File: doc/BRIEF.md
# Prioritized Interrupt Request Recognizer

This block turns a set of active-low interrupt request lines into one prioritized service request for a processor core. Each line is sampled on a selectable clock edge and passes a small glitch filter. Only requests that have been stable for a set number of samples count. The filtered lines are compared against the current 3-bit priority mask. The highest level above the mask is offered to the core as a pending request. The pending level is recomputed every cycle and never captured, so a higher level that arrives late still wins.

The core raises `boundary` when it can take an interrupt, for example at an instruction boundary or when a more urgent exception has finished. If a request is pending in that cycle, the block accepts it. In the next cycle it pulses `ack_valid`, presents the accepted level on `ack_level`, and loads that level into the mask. The top level is nonmaskable. It is edge-triggered: an asserting edge of its filtered line raises a request once, and the request persists until it is acknowledged. The request is raised again if the mask drops from the top value while the line is still held.

Top module: `irq_recognizer`

## Requirements
- R1: With the default sampling edge, each request line is sampled on the falling clock edge. A line driven just after a rising edge is seen as active before the second rising edge that follows.
- R2: A line counts as active only after 2 consecutive samples find it low, and as inactive only after 2 consecutive samples find it high. A low pulse seen by a single sample has no effect.
- R3: A request on a line for levels 1 to 6 is ignored while its level is less than or equal to the mask. `take` stays low and `pend_level` reads 0 unless another request qualifies.
- R4: When several qualifying requests exist, `pend_level` shows the highest one. It follows changes every cycle: a higher arrival replaces a lower one, and removing the higher one falls back to the lower one.
- R5: A pending request stays pending and is never acknowledged while `boundary` is low.
- R6: Level 7 (`irq_n[6]`) becomes pending on each asserting edge of its filtered line, whatever the mask, including mask 7. A line held low after its acknowledge does not become pending again on its own.
- R7: Level 7 becomes pending again when the mask changes from 7 to a lower value while the filtered level-7 line is still active. Lowering the mask while that line is inactive raises nothing.
- R8: When `boundary` is high in a cycle with `take` high, the next cycle shows `ack_valid` = 1 for one cycle, `ack_level` equal to the accepted level, and `mask` equal to that level. Otherwise `ack_level` reads 0.
- R9: After reset, `mask` = 7, `take` = 0, `pend_level` = 0 and `ack_valid` = 0. `mask_wr` loads `mask_wr_val` into the mask at the next edge, unless an acknowledge happens in the same cycle, in which case the acknowledge wins.
- R10: A level-7 request is cleared only by its acknowledge. It stays pending after its line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 7 | Active-low request lines; bit i is level i+1 |
| boundary | input | 1 | Core can accept an interrupt this cycle |
| mask_wr | input | 1 | Load `mask_wr_val` into the mask |
| mask_wr_val | input | 3 | New mask value |
| take | output | 1 | A request above the mask (or level 7) is pending |
| pend_level | output | 3 | Level of the pending request, 0 when none |
| ack_valid | output | 1 | One-cycle pulse after an accepted request |
| ack_level | output | 3 | Accepted level while `ack_valid` is high, else 0 |
| mask | output | 3 | Current priority mask |

## Verification
The block is driven with single-sample glitches, held requests, and overlapping requests that are added and removed. These inputs separate the filter, the highest-level selection and the absence of any captured level. Requests at, below and above a moving mask show whether the comparison is strict. A request timed just after a rising edge and checked a half cycle later tells falling-edge sampling apart from rising-edge sampling. The level-7 line is asserted, held, released and asserted again, with the mask lowered both while it is held and while it is released. An acknowledge collides with a mask write in the same cycle. Together these separate edge detection, re-arming on a mask drop, clear-only-on-acknowledge and write priority.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } samp_edge_e;
endpackage

// File: rtl/irq_filter.sv
module irq_filter
   import irq_rec_pkg::*;
#(
   parameter int         DEPTH = 2,
   parameter samp_edge_e EDGE  = EDGE_FALL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_n,
   output logic active
);
   logic [DEPTH-2:0] hist;
   logic [DEPTH-1:0] win;
   logic             all_on;
   logic             all_off;

   assign win     = {hist, ~line_n};
   assign all_on  = &win;
   assign all_off = ~|win;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("irq_filter: DEPTH must be at least 2");
      end

      if (EDGE == EDGE_FALL) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist   <= '0;
               active <= 1'b0;
            end else begin
               hist <= win[DEPTH-2:0];
               if (all_on)       active <= 1'b1;
               else if (all_off) active <= 1'b0;
            end
         end

         // R2: the filtered state only moves to the level the line just showed
         a_r2_change_follows_line: assert property (@(negedge clk) disable iff (!rst_n)
            !$stable(active) |-> (active == !$past(line_n)));
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist   <= '0;
               active <= 1'b0;
            end else begin
               hist <= win[DEPTH-2:0];
               if (all_on)       active <= 1'b1;
               else if (all_off) active <= 1'b0;
            end
         end

         // R2: same rule when sampling on the rising edge
         a_r2_change_follows_line: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(active) |-> (active == !$past(line_n)));
      end
   endgenerate
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
   parameter int LVL_W = 3,
   localparam int NL   = (1 << LVL_W) - 1
) (
   input  logic [NL-1:0]    on,
   output logic [LVL_W-1:0] lvl
);
   always_comb begin
      lvl = '0;
      for (int i = 0; i < NL; i++) begin
         if (on[i]) lvl = LVL_W'(i + 1);
      end
   end
endmodule

// File: rtl/irq_nmi.sv
module irq_nmi #(
   parameter int LVL_W       = 3,
   parameter int RESET_MASK  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_on,
   input  logic [LVL_W-1:0] mask,
   input  logic             ack,
   output logic             pend
);
   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'((1 << LVL_W) - 1);

   logic             line_q;
   logic [LVL_W-1:0] mask_q;
   logic             edge_hit;
   logic             drop_hit;

   assign edge_hit = line_on & ~line_q;
   assign drop_hit = line_on & (mask_q == TOP_LVL) & (mask != TOP_LVL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b0;
         mask_q <= LVL_W'(RESET_MASK);
         pend   <= 1'b0;
      end else begin
         line_q <= line_on;
         mask_q <= mask;
         pend   <= edge_hit | drop_hit | (pend & ~ack);
      end
   end

   // R10: a pending top-level request only goes away through its acknowledge
   a_r10_clear_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend) |-> $past(ack));
endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
   import irq_rec_pkg::*;
#(
   parameter int         LVL_W       = 3,
   parameter int         FILT_DEPTH  = 2,
   parameter samp_edge_e SAMPLE_EDGE = EDGE_FALL,
   parameter int         RESET_MASK  = (1 << LVL_W) - 1,
   localparam int        NL          = (1 << LVL_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NL-1:0]    irq_n,
   input  logic             boundary,
   input  logic             mask_wr,
   input  logic [LVL_W-1:0] mask_wr_val,
   output logic             take,
   output logic [LVL_W-1:0] pend_level,
   output logic             ack_valid,
   output logic [LVL_W-1:0] ack_level,
   output logic [LVL_W-1:0] mask
);
   localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(NL);

   logic [NL-1:0]    flt;
   logic [NL-1:0]    low_on;
   logic [LVL_W-1:0] low_lvl;
   logic             nmi_pend;
   logic             accept;
   logic             nmi_ack;

   generate
      if (LVL_W < 2 || LVL_W > 4) begin : g_bad_width
         $error("irq_recognizer: LVL_W must be 2 to 4");
      end
      if (RESET_MASK < 0 || RESET_MASK > NL) begin : g_bad_reset
         $error("irq_recognizer: RESET_MASK out of range");
      end

      for (genvar i = 0; i < NL; i++) begin : g_line
         irq_filter #(
            .DEPTH (FILT_DEPTH),
            .EDGE  (SAMPLE_EDGE)
         ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_n (irq_n[i]),
            .active (flt[i])
         );
      end
   endgenerate

   assign low_on = {1'b0, flt[NL-2:0]};

   irq_prio #(.LVL_W(LVL_W)) u_prio (
      .on  (low_on),
      .lvl (low_lvl)
   );

   irq_nmi #(.LVL_W(LVL_W), .RESET_MASK(RESET_MASK)) u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_on (flt[NL-1]),
      .mask    (mask),
      .ack     (nmi_ack),
      .pend    (nmi_pend)
   );

   assign pend_level = nmi_pend ? NMI_LVL : ((low_lvl > mask) ? low_lvl : '0);
   assign take       = (pend_level != '0);
   assign accept     = boundary & take;
   assign nmi_ack    = accept & (pend_level == NMI_LVL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask      <= LVL_W'(RESET_MASK);
         ack_valid <= 1'b0;
         ack_level <= '0;
      end else begin
         ack_valid <= accept;
         ack_level <= accept ? pend_level : '0;
         if (accept)       mask <= pend_level;
         else if (mask_wr) mask <= mask_wr_val;
      end
   end

   // R8: an acknowledged level is the mask in the cycle it is presented
   a_r8_mask_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> (mask == ack_level));

   // R5: no acknowledge without the core signalling a boundary
   a_r5_ack_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> ($past(boundary) && $past(take)));

   // R3: a maskable level accepted must have exceeded the mask it met
   a_r3_above_old_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_level != NMI_LVL) |-> (ack_level > $past(mask)));
endmodule

// File: tb/sim_irq_recognizer.sv
`timescale 1ns/100ps
module sim_irq_recognizer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] irq_n = 7'h7f;
   logic       boundary = 1'b0;
   logic       mask_wr = 1'b0;
   logic [2:0] mask_wr_val = 3'd0;
   logic       take;
   logic [2:0] pend_level;
   logic       ack_valid;
   logic [2:0] ack_level;
   logic [2:0] mask;

   int    n_checks = 0;
   int    n_fails  = 0;
   int    cycles   = 0;
   string cur_req  = "R9";
   bit    done     = 1'b0;

   always #2.5 clk = ~clk;

   irq_recognizer u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_n       (irq_n),
      .boundary    (boundary),
      .mask_wr     (mask_wr),
      .mask_wr_val (mask_wr_val),
      .take        (take),
      .pend_level  (pend_level),
      .ack_valid   (ack_valid),
      .ack_level   (ack_level),
      .mask        (mask)
   );

   // behavioural reference
   int cnt_on[7];
   int cnt_off[7];
   bit m_act[7];
   bit m_nmi, m_act7_q, m_ack_v;
   int m_mask, m_mask_d1, m_ack_l;

   function automatic int ref_pend();
      int hi = 0;
      if (m_nmi) return 7;
      for (int i = 0; i < 6; i++) if (m_act[i]) hi = i + 1;
      return (hi > m_mask) ? hi : 0;
   endfunction

   always @(negedge clk) begin
      for (int i = 0; i < 7; i++) begin
         if (!rst_n) begin
            cnt_on[i] = 0; cnt_off[i] = 0; m_act[i] = 1'b0;
         end else begin
            if (!irq_n[i]) begin cnt_on[i]++; cnt_off[i] = 0; end
            else begin cnt_off[i]++; cnt_on[i] = 0; end
            if (cnt_on[i] >= 2) m_act[i] = 1'b1;
            if (cnt_off[i] >= 2) m_act[i] = 1'b0;
         end
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_nmi = 0; m_act7_q = 0; m_ack_v = 0; m_ack_l = 0;
         m_mask = 7; m_mask_d1 = 7;
      end else begin
         int  p;
         bit  acc, newn, nx_nmi;
         int  nx_mask;
         p      = ref_pend();
         acc    = boundary && (p != 0);
         newn   = (m_act[6] && !m_act7_q) || (m_mask_d1 == 7 && m_mask != 7 && m_act[6]);
         nx_nmi = newn || (m_nmi && !(acc && p == 7));
         nx_mask = acc ? p : (mask_wr ? int'(mask_wr_val) : m_mask);
         m_ack_v   = acc;
         m_ack_l   = acc ? p : 0;
         m_mask_d1 = m_mask;
         m_mask    = nx_mask;
         m_act7_q  = m_act[6];
         m_nmi     = nx_nmi;
      end
   end

   task automatic chk(string tag, int act, int exp, string what);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk(cur_req, int'(pend_level), ref_pend(), "pend_level");
         chk(cur_req, int'(take), int'(ref_pend() != 0), "take");
         chk(cur_req, int'(mask), m_mask, "mask");
         chk(cur_req, int'(ack_valid), int'(m_ack_v), "ack_valid");
         chk(cur_req, int'(ack_level), m_ack_l, "ack_level");
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic write_mask(int v);
      mask_wr = 1'b1; mask_wr_val = 3'(v);
      step(1);
      mask_wr = 1'b0;
   endtask

   task automatic pulse_boundary();
      boundary = 1'b1;
      step(1);
      boundary = 1'b0;
   endtask

   initial begin
      step(4);
      rst_n = 1'b1;
      step(1);
      cur_req = "R9";
      chk("R9", int'(mask), 7, "reset mask");
      chk("R9", int'(take), 0, "reset take");
      chk("R9", int'(pend_level), 0, "reset pend_level");
      chk("R9", int'(ack_valid), 0, "reset ack_valid");
      write_mask(0);
      chk("R9", int'(mask), 0, "mask write");

      cur_req = "R2";
      irq_n[2] = 1'b0; step(1); irq_n[2] = 1'b1;
      step(4);
      chk("R2", int'(take), 0, "single-sample glitch ignored");

      cur_req = "R1";
      irq_n[2] = 1'b0;
      #7;
      chk("R1", int'(pend_level), 3, "falling-edge sampling latency");
      step(1);
      cur_req = "R5";
      step(6);
      chk("R5", int'(ack_valid), 0, "no ack without boundary");
      chk("R5", int'(pend_level), 3, "request still pending");

      cur_req = "R4";
      irq_n[4] = 1'b0; step(4);
      chk("R4", int'(pend_level), 5, "higher arrival wins");
      irq_n[4] = 1'b1; step(4);
      chk("R4", int'(pend_level), 3, "falls back, not latched");

      cur_req = "R8";
      pulse_boundary();
      chk("R8", int'(ack_valid), 1, "ack pulse");
      chk("R8", int'(ack_level), 3, "ack level");
      chk("R8", int'(mask), 3, "mask loaded");
      step(1);
      chk("R8", int'(ack_valid), 0, "ack one cycle");
      cur_req = "R3";
      chk("R3", int'(pend_level), 0, "level equal to mask ignored");
      irq_n[1] = 1'b0; step(4);
      chk("R3", int'(pend_level), 0, "lower level ignored");
      cur_req = "R4";
      irq_n[3] = 1'b0; step(4);
      chk("R4", int'(pend_level), 4, "highest above mask");
      cur_req = "R3";
      write_mask(7);
      chk("R3", int'(pend_level), 0, "masked by 7");
      irq_n = 7'h7f; step(4);

      cur_req = "R6";
      irq_n[6] = 1'b0; step(4);
      chk("R6", int'(pend_level), 7, "nmi passes mask 7");
      pulse_boundary();
      chk("R6", int'(ack_level), 7, "nmi ack");
      step(4);
      chk("R6", int'(take), 0, "held line does not re-fire");

      cur_req = "R7";
      write_mask(2);
      step(3);
      chk("R7", int'(pend_level), 7, "mask drop re-arms nmi");
      cur_req = "R9";
      boundary = 1'b1; mask_wr = 1'b1; mask_wr_val = 3'd1;
      step(1);
      boundary = 1'b0; mask_wr = 1'b0;
      chk("R9", int'(mask), 7, "ack beats mask write");
      step(3);
      chk("R9", int'(take), 0, "nothing pending after ack");

      cur_req = "R10";
      irq_n[6] = 1'b1; step(4);
      irq_n[6] = 1'b0; step(4);
      irq_n[6] = 1'b1; step(6);
      chk("R10", int'(pend_level), 7, "nmi survives line release");
      pulse_boundary();
      step(2);
      chk("R10", int'(take), 0, "nmi cleared by ack");

      cur_req = "R7";
      write_mask(0);
      step(3);
      chk("R7", int'(take), 0, "mask drop with line idle raises nothing");

      step(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule